// File: doc/BRIEF.md
# Two-Bus Register File Datapath

This block is the execute core of a small processor: seven general registers, two source multiplexers that form operand buses A and B, an eleven-function ALU, and a write-back decoder. Every cycle a control word, driven straight onto the input ports, picks what goes onto each bus, which ALU function combines them, and which register captures the result at the next rising clock edge. A source code of zero puts the external data input on the bus instead of a register. A destination code of zero writes nothing.

The ALU result, a carry/borrow flag and a zero flag are visible on output ports in the same cycle as the control word. One cycle therefore does a full register-to-register operation, for example `R3 <- R1 + R2` with A-source 1, B-source 2, operation ADD and destination 3.

Top module: `busdp_core`

## Requirements
- R1: A synchronous active-high reset clears all seven registers to zero at the clock edge where it is sampled high.
- R2: Bus A carries the external input when its 3-bit source code is 0, and register k when the code is k (1 to 7). Operation code 0000 passes bus A unchanged to the result.
- R3: Bus B is selected the same way from its own 3-bit source code. With bus A holding zero, operation OR shows bus B on the result.
- R4: A destination code k in 1 to 7 loads the result into register k at the next rising edge. All other registers keep their values.
- R5: Destination code 0 leaves all seven registers unchanged.
- R6: Arithmetic operation codes are 0001 A+1, 0010 A+B, 0011 A-B and 0100 A-1. Results wrap modulo 2^W. Carry is the carry-out for 0001 and 0010, and the borrow (A<B, or A==0 for decrement) for 0011 and 0100.
- R7: Logic operation codes are 0000 A, 0101 A AND B, 0110 A OR B, 0111 A XOR B and 1000 NOT A. Carry is 0 for all of them.
- R8: Operation code 1001 shifts A right by one and 1010 shifts A left by one. Both are logical shifts that fill the vacated bit with 0. Carry is the bit shifted out.
- R9: Operation codes 1011 to 1111 give a result of zero and a carry of 0. The selected destination is still written with that zero.
- R10: The zero flag is 1 exactly when the result is all zeros.
- R11: When one register is both a source and the destination in the same cycle, the bus carries its old value. The new value appears only after the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ext_in | input | W | External data that can be placed on either bus |
| sel_a | input | 3 | Bus A source: 0 external input, 1-7 register |
| sel_b | input | 3 | Bus B source: 0 external input, 1-7 register |
| sel_d | input | 3 | Destination: 0 no write, 1-7 register |
| op | input | 4 | ALU operation code |
| result | output | W | ALU result, the write-back value |
| carry | output | 1 | Carry or borrow, or the shifted-out bit |
| zero | output | 1 | Result is all zeros |

## Verification
The hardest case to reach is a register that is read and written in the same cycle, particularly when the wrap and borrow corners coincide. Examples are incrementing 0xFF back into itself, or decrementing zero into itself and then reading the new value one cycle later.

The stimulus first loads chosen boundary values through the external input. It then issues directed same-register read-modify-write words and follows them with long randomized control-word runs, with every field drawn across its whole range, including destination 0 and the undefined operation codes. The behavioural model checks the result and both flags on every cycle.

// File: rtl/busdp_pkg.sv
package busdp_pkg;
    localparam int SEL_W  = 3;
    localparam int NUM_RG = (1 << SEL_W) - 1;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_PASS = 4'd0,
        OP_INC  = 4'd1,
        OP_ADD  = 4'd2,
        OP_SUB  = 4'd3,
        OP_DEC  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_NOT  = 4'd8,
        OP_SHR  = 4'd9,
        OP_SHL  = 4'd10
    } alu_op_e;
endpackage

// File: rtl/busdp_regbank.sv
module busdp_regbank
    import busdp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [SEL_W-1:0]               wr_sel,
    input  logic [W-1:0]                   wr_data,
    output logic [NUM_RG:1][W-1:0]         rd_regs
);
    typedef struct packed {
        logic [NUM_RG:1][W-1:0] r;
    } bank_t;

    bank_t         st_d, st_q;
    logic [NUM_RG:1] wr_en;

    // destination decoder: one enable per register, none for code 0
    for (genvar k = 1; k <= NUM_RG; k++) begin : g_dec
        assign wr_en[k] = (wr_sel == SEL_W'(k));
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            for (int k = 1; k <= NUM_RG; k++) begin
                if (wr_en[k]) st_d.r[k] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_regs = st_q.r;
endmodule

// File: rtl/busdp_srcmux.sv
module busdp_srcmux
    import busdp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [NUM_RG:1][W-1:0] regs,
    input  logic [W-1:0]           ext,
    input  logic [SEL_W-1:0]       sel,
    output logic [W-1:0]           bus
);
    always_comb begin
        bus = ext;
        for (int k = 1; k <= NUM_RG; k++) begin
            if (sel == SEL_W'(k)) bus = regs[k];
        end
    end
endmodule

// File: rtl/busdp_alu.sv
module busdp_alu
    import busdp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [OP_W-1:0] op,
    output logic [W-1:0]    y,
    output logic            cy,
    output logic            z
);
    localparam logic [W:0] ONE_X = (W+1)'(1);

    logic [W:0] sum_ab, sum_inc, dif_ab, dif_dec;

    always_comb begin
        sum_ab  = {1'b0, a} + {1'b0, b};
        sum_inc = {1'b0, a} + ONE_X;
        dif_ab  = {1'b0, a} - {1'b0, b};
        dif_dec = {1'b0, a} - ONE_X;
        y  = '0;
        cy = 1'b0;
        case (op)
            OP_PASS: y = a;
            OP_INC:  {cy, y} = sum_inc;
            OP_ADD:  {cy, y} = sum_ab;
            OP_SUB:  {cy, y} = dif_ab;
            OP_DEC:  {cy, y} = dif_dec;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOT:  y = ~a;
            OP_SHR: begin
                y  = {1'b0, a[W-1:1]};
                cy = a[0];
            end
            OP_SHL: begin
                y  = {a[W-2:0], 1'b0};
                cy = a[W-1];
            end
            default: begin
                y  = '0;
                cy = 1'b0;
            end
        endcase
        z = (y == '0);
    end
endmodule

// File: rtl/busdp_core.sv
module busdp_core
    import busdp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     ext_in,
    input  logic [2:0]       sel_a,
    input  logic [2:0]       sel_b,
    input  logic [2:0]       sel_d,
    input  logic [3:0]       op,
    output logic [W-1:0]     result,
    output logic             carry,
    output logic             zero
);
    logic [NUM_RG:1][W-1:0] regs;
    logic [W-1:0]           bus_a, bus_b;

    busdp_regbank #(.W(W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_sel  (sel_d),
        .wr_data (result),
        .rd_regs (regs)
    );

    busdp_srcmux #(.W(W)) u_mux_a (
        .regs (regs),
        .ext  (ext_in),
        .sel  (sel_a),
        .bus  (bus_a)
    );

    busdp_srcmux #(.W(W)) u_mux_b (
        .regs (regs),
        .ext  (ext_in),
        .sel  (sel_b),
        .bus  (bus_b)
    );

    busdp_alu #(.W(W)) u_alu (
        .a  (bus_a),
        .b  (bus_b),
        .op (op),
        .y  (result),
        .cy (carry),
        .z  (zero)
    );
endmodule

// File: rtl/busdp_chk.sv
module busdp_chk
    import busdp_pkg::*;
#(
    parameter int W = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic [W-1:0]           ext_in,
    input logic [2:0]             sel_a,
    input logic [2:0]             sel_d,
    input logic [3:0]             op,
    input logic [W-1:0]           result,
    input logic                   carry,
    input logic                   zero,
    input logic [NUM_RG:1][W-1:0] regs
);
    // R1: reset empties the bank
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (regs == '0));

    // R2: code 0 on bus A with pass-through shows the external input
    p_ext_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd0 && sel_a == 3'd0) |-> (result == ext_in));

    // R9: undefined codes drive a zero result with zero flag set, carry clear
    p_undef_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (op > 4'd10) |-> (result == '0 && zero && !carry));

    for (genvar k = 1; k <= NUM_RG; k++) begin : g_reg
        // R2: register source code k on bus A
        p_reg_pass_r2: assert property (@(posedge clk) disable iff (rst)
            (op == 4'd0 && sel_a == 3'(k)) |-> (result == regs[k]));
        // R4: decoded destination captures the result
        p_dest_load_r4: assert property (@(posedge clk) disable iff (rst)
            (sel_d == 3'(k)) |=> (regs[k] == $past(result)));
        // R5: any other destination code leaves this register alone
        p_dest_hold_r5: assert property (@(posedge clk) disable iff (rst)
            (sel_d != 3'(k)) |=> $stable(regs[k]));
    end
endmodule

bind busdp_core busdp_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ext_in (ext_in),
    .sel_a  (sel_a),
    .sel_d  (sel_d),
    .op     (op),
    .result (result),
    .carry  (carry),
    .zero   (zero),
    .regs   (regs)
);

// File: tb/sim_busdp_core.sv
module sim_busdp_core;
    localparam int W    = 8;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] ext_in = '0;
    logic [2:0]   sel_a = '0, sel_b = '0, sel_d = '0;
    logic [3:0]   op = '0;
    logic [W-1:0] result;
    logic         carry, zero;

    int n_chk  = 0;
    int n_fail = 0;
    int ref_r[8];
    bit done = 0;

    always #5 clk = ~clk;

    busdp_core #(.W(W)) u0 (
        .clk(clk), .rst(rst), .ext_in(ext_in),
        .sel_a(sel_a), .sel_b(sel_b), .sel_d(sel_d), .op(op),
        .result(result), .carry(carry), .zero(zero)
    );

    function automatic void model(input int a, input int b, input int o,
                                  output int r, output int c);
        int t;
        c = 0;
        case (o)
            0:  r = a;
            1:  begin t = a + 1; r = t & MASK; c = t >> W; end
            2:  begin t = a + b; r = t & MASK; c = t >> W; end
            3:  begin r = (a - b) & MASK; c = (a < b) ? 1 : 0; end
            4:  begin r = (a - 1) & MASK; c = (a == 0) ? 1 : 0; end
            5:  r = a & b;
            6:  r = a | b;
            7:  r = a ^ b;
            8:  r = (~a) & MASK;
            9:  begin r = a >> 1; c = a & 1; end
            10: begin r = (a << 1) & MASK; c = (a >> (W-1)) & 1; end
            default: r = 0;
        endcase
    endfunction

    function automatic string op_tag(input int o);
        if (o >= 1 && o <= 4) return "R6";
        if (o == 9 || o == 10) return "R8";
        if (o > 10) return "R9";
        return "R7";
    endfunction

    // one control word: drive at negedge, check mid-cycle, then model the edge
    task automatic step(input int a, input int b, input int d, input int o,
                        input int x, input string tag);
        int va, vb, er, ec, ez;
        @(negedge clk);
        sel_a = 3'(a); sel_b = 3'(b); sel_d = 3'(d); op = 4'(o); ext_in = W'(x);
        #1;
        va = (a == 0) ? x : ref_r[a];
        vb = (b == 0) ? x : ref_r[b];
        model(va, vb, o, er, ec);
        ez = (er == 0) ? 1 : 0;
        n_chk++;
        if (int'(result) != er || int'(carry) != ec || int'(zero) != ez) begin
            n_fail++;
            $display("FAIL %s (R10 flag) op=%0d a=%0d b=%0d: result=%0d carry=%0d zero=%0d expected %0d %0d %0d",
                     tag, o, a, b, result, carry, zero, er, ec, ez);
        end
        @(posedge clk);
        if (d != 0) ref_r[d] = er;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sel_d = '0; op = '0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 8; k++) ref_r[k] = 0;
    endtask

    task automatic read_all(input string tag);
        for (int k = 1; k <= 7; k++) step(k, 0, 0, 0, 8'h5A, tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) ref_r[k] = 0;
        repeat (3) @(posedge clk);
        do_reset();
        read_all("R1");
        // R4: load distinct values through the external input
        for (int k = 1; k <= 7; k++) step(0, 0, k, 0, 16 * k + 3, "R4");
        read_all("R4");
        // R2 / R3: every source code on each bus
        for (int k = 0; k <= 7; k++) step(k, 0, 0, 0, 8'hC4, "R2");
        for (int k = 0; k <= 7; k++) step(0, k, 0, 6, 0, "R3");
        // R5: destination 0 writes nothing
        step(0, 0, 0, 0, 8'hEE, "R5");
        step(1, 2, 0, 2, 0, "R5");
        read_all("R5");
        // worked example: R3 <- R1 + R2
        step(1, 2, 3, 2, 0, "R6");
        step(3, 0, 0, 0, 0, "R4");
        // R11: same register read and written, with wrap and borrow corners
        step(0, 0, 5, 0, 8'hFF, "R11");
        step(5, 0, 5, 1, 0, "R11");
        step(5, 0, 0, 0, 0, "R11");
        step(5, 0, 5, 4, 0, "R11");
        step(5, 0, 0, 0, 0, "R11");
        step(0, 0, 6, 0, 8'h81, "R8");
        step(6, 0, 6, 10, 0, "R8");
        step(6, 0, 6, 9, 0, "R8");
        step(6, 6, 6, 3, 0, "R11");
        step(6, 0, 0, 0, 0, "R10");
        // R9: undefined codes still write zero
        for (int o = 11; o <= 15; o++) begin
            step(1, 2, 7, o, 8'h33, "R9");
            step(7, 0, 0, 0, 0, "R9");
        end
        // every defined operation with mixed buses
        for (int o = 0; o <= 10; o++) step(2, 0, 4, o, 8'hA5, op_tag(o));
        // randomized control words
        for (int i = 0; i < 1500; i++) begin
            int o;
            o = int'($urandom_range(15, 0));
            step(int'($urandom_range(7, 0)), int'($urandom_range(7, 0)),
                 int'($urandom_range(7, 0)), o, int'($urandom_range(255, 0)), op_tag(o));
        end
        // R1: reset again after the bank has been filled
        do_reset();
        read_all("R1");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule